// File: doc/BRIEF.md
# Configurable Multi-Mode PWM Channel

This block produces one pulse-width-modulated output from a small register set. A free-running counter is compared against a duty value inside a period that is counted in counter ticks. A control word chooses the timing and the levels. The counter can run left-aligned (a sawtooth from zero up to period minus one) or centre-aligned (up, then back down). The run can be a single period or can repeat. The active level of the duty phase and the level driven while stopped are chosen separately. The counter advances either on every clock or only on cycles where an external scaled-tick enable is high.

Software programs the period and duty while the channel is stopped and then sets the enable bit. Period and duty written during a run are held in shadow copies. They take effect only when the current period ends, so a pulse is never cut short or stretched. When a single-period run ends, the hardware clears the enable bit and raises a sticky status flag. Software clears the flag by writing a one. The interrupt output is the flag gated by an interrupt-enable bit.

Register addresses (word index on `regAddr`):

| Index | Register |
|---|---|
| 0 | counter (read-only) |
| 1 | period |
| 2 | duty |
| 3 | control |
| 4 | status (bit 0) |
| 5 | interrupt enable (bit 0) |

Top module: `pwm_channel`

## Requirements
- R1: After reset:
  - `pwmOut` and `irqOut` are 0.
  - Every register reads 0.
- R2: While control bit 0 (enable) is 0:
  - The counter reads 0.
  - `pwmOut` equals control bit 4 (idle level).
- R3: Left-aligned mode (control bit 5 = 0), while enabled:
  - The counter steps 0, 1, …, period−1 and then wraps to 0.
  - The duty phase lasts while the count is below the duty value.
  - A period of 0 is treated as a period of one tick.
- R4: Centre-aligned mode (control bit 5 = 1), while enabled:
  - The counter steps up from 0 to period−1, holds that top value for one more tick and then steps back down to 0, so a full cycle is 2×period ticks.
  - The duty phase lasts while count + duty ≥ period, which centres the pulse on the top of the count.
- R5: Control bit 3 sets the duty-phase level:
  - 1 makes the duty phase high and the rest of the period low.
  - 0 gives the inverse.
- R6: The active period and duty are copied from the period and duty registers in two cases only:
  - while the channel is disabled;
  - at the end of each period.
  A write during a run does not change the current period.
- R7: With control bit 1 = 0 (one-shot), when the period ends:
  - Control bit 0 clears.
  - Status bit 0 sets.
  - The output returns to the idle level.
- R8: With control bit 1 = 1 (continuous), the enable bit stays set across period ends and the counter keeps cycling.
- R9: With control bit 9 = 1, the counter advances only on cycles where `scaleTick` is 1. With bit 9 = 0 it advances every cycle.
- R10: Status bit 0 and the interrupt:
  - Writing 1 to status bit 0 clears it.
  - If a one-shot end and that clearing write fall in the same cycle, the status stays set.
  - `irqOut` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R11: Register access rules:
  - Writes to the counter register are ignored.
  - Control bits other than 0, 1, 3, 4, 5 and 9 read back 0.
  - A write to the control register in the same cycle as a one-shot end takes precedence over the hardware clearing of the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scaleTick | input | 1 | Scaled counter-advance enable, used when control bit 9 is set |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| pwmOut | output | 1 | PWM output |
| irqOut | output | 1 | Interrupt request (status AND enable) |

## Verification
Two pairs of actions can land in the same cycle: the hardware's end-of-run update and the software's register writes.
- **Status flag.** The bench counts the register slots from the enabling write to the last tick of a three-tick one-shot run. It places a write-one-to-clear to the status register exactly in that final cycle. The status flag must then read back as set.
- **Enable bit.** A control write arriving in the end-of-run cycle must win over the hardware clearing of the enable bit.
- **Cycle-by-cycle model.** A behavioural model in the bench predicts the output, the interrupt and the read data on every cycle, so any wrong ordering of these updates shows as a miscompare.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;

  // control word bit positions
  localparam int EN_BIT     = 0;
  localparam int CONT_BIT   = 1;
  localparam int DPOL_BIT   = 3;
  localparam int IPOL_BIT   = 4;
  localparam int CENTER_BIT = 5;
  localparam int CLKSEL_BIT = 9;

  localparam logic [ADDR_W-1:0] ADDR_CNT    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_IEN    = 3'd5;

  // strobes from the control half to the counting datapath
  typedef struct packed {
    logic run;       // channel enabled
    logic advance;   // counter may step this cycle
    logic center;    // up/down counting
    logic dutyHigh;  // level during duty phase
    logic idleHigh;  // level while stopped
  } pwmStrobes_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scaleTick,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                periodEnd,
  output pwmStrobes_t         strobes,
  output logic [DATA_W-1:0]   periodQ,
  output logic [DATA_W-1:0]   dutyQ,
  output logic [DATA_W-1:0]   ctrlQ,
  output logic                statusQ,
  output logic                intEnQ
);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << EN_BIT) | (1 << CONT_BIT) |
    (1 << DPOL_BIT) | (1 << IPOL_BIT) | (1 << CENTER_BIT) | (1 << CLKSEL_BIT));

  logic wrPeriod, wrDuty, wrCtrl, wrStat, wrIen;
  logic oneShotDone;

  always_comb begin
    wrPeriod = regWr && (regAddr == ADDR_PERIOD);
    wrDuty   = regWr && (regAddr == ADDR_DUTY);
    wrCtrl   = regWr && (regAddr == ADDR_CTRL);
    wrStat   = regWr && (regAddr == ADDR_STAT);
    wrIen    = regWr && (regAddr == ADDR_IEN);
    oneShotDone = periodEnd && !ctrlQ[CONT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
      dutyQ   <= '0;
      ctrlQ   <= '0;
      statusQ <= 1'b0;
      intEnQ  <= 1'b0;
    end else begin
      if (wrPeriod) periodQ <= regWrData;
      if (wrDuty)   dutyQ   <= regWrData;
      // software write has priority over the hardware enable clear
      if (wrCtrl)           ctrlQ         <= regWrData & CTRL_MASK;
      else if (oneShotDone) ctrlQ[EN_BIT] <= 1'b0;
      // hardware set has priority over write-one-to-clear
      if (oneShotDone)                 statusQ <= 1'b1;
      else if (wrStat && regWrData[0]) statusQ <= 1'b0;
      if (wrIen) intEnQ <= regWrData[0];
    end
  end

  always_comb begin
    strobes.run      = ctrlQ[EN_BIT];
    strobes.advance  = ctrlQ[CLKSEL_BIT] ? scaleTick : 1'b1;
    strobes.center   = ctrlQ[CENTER_BIT];
    strobes.dutyHigh = ctrlQ[DPOL_BIT];
    strobes.idleHigh = ctrlQ[IPOL_BIT];
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobes_t       strobes,
  input  logic [DATA_W-1:0] periodReg,
  input  logic [DATA_W-1:0] dutyReg,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] actPeriod,
  output logic              periodEnd,
  output logic              pwmOut
);
  localparam int WIDE_W = DATA_W + 1;

  logic [DATA_W-1:0] actDuty;
  logic              countUp;
  logic [WIDE_W-1:0] cntInc, cntPlusDuty;
  logic              atTop, atBottom, inDuty;

  always_comb begin
    cntInc      = {1'b0, cntQ} + WIDE_W'(1);
    cntPlusDuty = {1'b0, cntQ} + {1'b0, actDuty};
    atTop       = cntInc >= {1'b0, actPeriod};
    atBottom    = (cntQ == '0);
    periodEnd   = strobes.run && strobes.advance &&
                  (strobes.center ? (!countUp && atBottom) : atTop);
    inDuty      = strobes.center ? (cntPlusDuty >= {1'b0, actPeriod})
                                 : (cntQ < actDuty);
    pwmOut      = strobes.run ? (inDuty ? strobes.dutyHigh : !strobes.dutyHigh)
                              : strobes.idleHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      countUp   <= 1'b1;
      actPeriod <= '0;
      actDuty   <= '0;
    end else if (!strobes.run) begin
      cntQ      <= '0;
      countUp   <= 1'b1;
      actPeriod <= periodReg;
      actDuty   <= dutyReg;
    end else begin
      if (periodEnd) begin
        actPeriod <= periodReg;
        actDuty   <= dutyReg;
      end
      if (strobes.advance) begin
        if (!strobes.center) begin
          cntQ <= atTop ? '0 : cntInc[DATA_W-1:0];
        end else if (countUp) begin
          if (atTop) countUp <= 1'b0;
          else       cntQ    <= cntInc[DATA_W-1:0];
        end else begin
          if (atBottom) countUp <= 1'b1;
          else          cntQ    <= cntQ - DATA_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scaleTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              pwmOut,
  output logic              irqOut
);
  pwmStrobes_t       strobes;
  logic [DATA_W-1:0] periodQ, dutyQ, ctrlQ, cntQ, actPeriod;
  logic              statusQ, intEnQ, periodEnd;

  pwm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .scaleTick(scaleTick),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .periodEnd(periodEnd), .strobes(strobes),
    .periodQ(periodQ), .dutyQ(dutyQ), .ctrlQ(ctrlQ),
    .statusQ(statusQ), .intEnQ(intEnQ)
  );

  pwm_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .periodReg(periodQ), .dutyReg(dutyQ),
    .cntQ(cntQ), .actPeriod(actPeriod),
    .periodEnd(periodEnd), .pwmOut(pwmOut)
  );

  assign irqOut = statusQ & intEnQ;

  always_comb begin
    case (regAddr)
      ADDR_CNT:    regRdData = cntQ;
      ADDR_PERIOD: regRdData = periodQ;
      ADDR_DUTY:   regRdData = dutyQ;
      ADDR_CTRL:   regRdData = ctrlQ;
      ADDR_STAT:   regRdData = {{(DATA_W-1){1'b0}}, statusQ};
      ADDR_IEN:    regRdData = {{(DATA_W-1){1'b0}}, intEnQ};
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              scaleTick,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              pwmOut,
  input logic [DATA_W-1:0] ctrlQ,
  input logic              statusQ,
  input logic [DATA_W-1:0] cntQ,
  input logic [DATA_W-1:0] actPeriod,
  input logic              periodEnd
);
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[EN_BIT] && !regWr) |=> (cntQ == '0 && pwmOut == $past(ctrlQ[IPOL_BIT])));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0) || (cntQ < actPeriod));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[EN_BIT] && !periodEnd) |=> $stable(actPeriod));

  assert_oneshot_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && !ctrlQ[CONT_BIT] && !(regWr && regAddr == ADDR_CTRL))
      |=> (!ctrlQ[EN_BIT] && statusQ));

  assert_continuous_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && ctrlQ[CONT_BIT] && !regWr) |=> ctrlQ[EN_BIT]);

  assert_tick_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[EN_BIT] && ctrlQ[CLKSEL_BIT] && !scaleTick && !regWr) |=> $stable(cntQ));

  assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_STAT && regWrData[0] && !periodEnd) |=> !statusQ);

  assert_status_setwins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && !ctrlQ[CONT_BIT]) |=> statusQ);
endmodule

bind pwm_channel pwm_channel_chk #(.DATA_W(DATA_W)) u_pwmChk (
  .clk(clk), .rstN(rstN), .scaleTick(scaleTick), .regWr(regWr),
  .regAddr(regAddr), .regWrData(regWrData), .pwmOut(pwmOut),
  .ctrlQ(ctrlQ), .statusQ(statusQ), .cntQ(cntQ),
  .actPeriod(actPeriod), .periodEnd(periodEnd)
);

// File: tb/test_pwm_channel.sv
module test_pwm_channel;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scaleTick = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pwmOut, irqOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  pwm_channel #(.DATA_W(32)) i_pwm_channel (
    .clk(clk), .rstN(rstN), .scaleTick(scaleTick), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pwmOut(pwmOut), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit     mEn, mCont, mDpol, mIpol, mCent, mSel, mUp, mStat, mIen;
  longint mPer, mDuty, mCnt, mActP, mActD;

  always @(posedge clk) begin
    bit tick, endP, done;
    if (!rstN) begin
      {mEn, mCont, mDpol, mIpol, mCent, mSel, mStat, mIen} = '0;
      mUp = 1; mPer = 0; mDuty = 0; mCnt = 0; mActP = 0; mActD = 0;
    end else begin
      tick = mSel ? scaleTick : 1'b1;
      endP = mEn && tick && (mCent ? (!mUp && mCnt == 0) : (mCnt + 1 >= mActP));
      done = endP && !mCont;
      if (!mEn) begin
        mCnt = 0; mUp = 1; mActP = mPer; mActD = mDuty;
      end else begin
        if (tick) begin
          if (!mCent) mCnt = (mCnt + 1 >= mActP) ? 0 : mCnt + 1;
          else if (mUp) begin
            if (mCnt + 1 >= mActP) mUp = 0; else mCnt = mCnt + 1;
          end else begin
            if (mCnt == 0) mUp = 1; else mCnt = mCnt - 1;
          end
        end
        if (endP) begin mActP = mPer; mActD = mDuty; end
      end
      if (regWr) begin
        case (regAddr)
          3'd1: mPer = regWrData;
          3'd2: mDuty = regWrData;
          3'd5: mIen = regWrData[0];
          default: ;
        endcase
      end
      if (regWr && regAddr == 3'd3) begin
        mEn = regWrData[0]; mCont = regWrData[1]; mDpol = regWrData[3];
        mIpol = regWrData[4]; mCent = regWrData[5]; mSel = regWrData[9];
      end else if (done) mEn = 0;
      if (done) mStat = 1;
      else if (regWr && regAddr == 3'd4 && regWrData[0]) mStat = 0;
    end
  end

  function automatic bit expPwm();
    bit inD;
    inD = mCent ? (mCnt + mActD >= mActP) : (mCnt < mActD);
    return mEn ? (inD ? mDpol : !mDpol) : mIpol;
  endfunction

  function automatic logic [31:0] expRd(logic [2:0] a);
    case (a)
      3'd0: return 32'(mCnt);
      3'd1: return 32'(mPer);
      3'd2: return 32'(mDuty);
      3'd3: return {22'd0, mSel, 3'd0, mCent, mIpol, mDpol, 1'b0, mCont, mEn};
      3'd4: return {31'd0, mStat};
      3'd5: return {31'd0, mIen};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(!mEn ? "R2" : (mSel ? "R9" : (mCent ? "R4" : "R3")), "pwmOut", pwmOut, expPwm());
      chk("R10", "irqOut", irqOut, mStat && mIen);
      chk(regAddr == 3'd4 ? "R10" : (regAddr == 3'd0 ? "R3" : "R11"), "regRdData",
          regRdData, expRd(regAddr));
    end
  end

  // scaled tick: high one cycle in three
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #2;
      div = (div == 2) ? 0 : div + 1;
      scaleTick = (div == 2);
    end
  end

  // ---------------- stimulus helpers (one register slot each) ----------------
  task automatic slotWrite(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #2;
    regWr = 1'b1; regAddr = a; regWrData = d;
  endtask

  task automatic slotIdle(logic [2:0] a);
    @(posedge clk); #2;
    regWr = 1'b0; regAddr = a;
  endtask

  task automatic readCheck(logic [2:0] a, logic [31:0] exp, string tag);
    slotIdle(a);
    @(negedge clk);
    chk(tag, "read", regRdData, exp);
  endtask

  task automatic countHighs(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      slotIdle(3'd0);
      @(negedge clk);
      if (pwmOut) h++;
    end
  endtask

  // watchdog
  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int h;
    logic [31:0] prev;
    int changes;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pwmOut in reset", pwmOut, 0);
    chk("R1", "irqOut in reset", irqOut, 0);
    @(posedge clk); #2 rstN = 1'b1;
    for (int a = 0; a < 6; a++) readCheck(3'(a), 32'd0, "R1");

    // R11: counter read-only, unused control bits read 0
    slotWrite(3'd0, 32'h55);
    readCheck(3'd0, 32'd0, "R11");
    slotWrite(3'd3, 32'hFFFF_FC04);
    readCheck(3'd3, 32'd0, "R11");

    // R2: idle level high while disabled
    slotWrite(3'd3, 32'h10);
    slotIdle(3'd0);
    @(negedge clk);
    chk("R2", "idle high", pwmOut, 1);
    chk("R2", "counter held", regRdData, 0);

    // R3/R8: left aligned continuous, P=5 D=2 positive
    slotWrite(3'd1, 32'd5);
    slotWrite(3'd2, 32'd2);
    slotWrite(3'd3, 32'h0B);
    slotIdle(3'd0);
    countHighs(10, h);
    chk("R3", "left highs in 10", h, 4);
    repeat (10) slotIdle(3'd0);
    readCheck(3'd3, 32'h0B, "R8");

    // R5: negative duty polarity, P=4 D=1
    slotWrite(3'd3, 32'h0);
    slotWrite(3'd1, 32'd4);
    slotWrite(3'd2, 32'd1);
    slotWrite(3'd3, 32'h03);
    slotIdle(3'd0);
    countHighs(8, h);
    chk("R5", "negative highs in 8", h, 6);

    // R4: centre aligned, P=4 D=1 -> 2 high ticks per 8
    slotWrite(3'd3, 32'h0);
    slotWrite(3'd3, 32'h2B);
    slotIdle(3'd0);
    countHighs(16, h);
    chk("R4", "centre highs in 16", h, 4);

    // R6: duty written mid-run waits for the period end
    slotWrite(3'd3, 32'h0);
    slotWrite(3'd1, 32'd10);
    slotWrite(3'd2, 32'd0);
    slotWrite(3'd3, 32'h0B);
    slotWrite(3'd2, 32'd10);
    countHighs(3, h);
    chk("R6", "old duty kept", h, 0);
    repeat (10) slotIdle(3'd0);
    countHighs(3, h);
    chk("R6", "new duty applied", h, 3);

    // R9: scaled clock, P=4 -> 4 counter changes in 12 cycles
    slotWrite(3'd3, 32'h0);
    slotWrite(3'd1, 32'd4);
    slotWrite(3'd2, 32'd1);
    slotWrite(3'd3, 32'h20B);
    slotIdle(3'd0);
    @(negedge clk);
    prev = regRdData;
    changes = 0;
    for (int i = 0; i < 12; i++) begin
      slotIdle(3'd0);
      @(negedge clk);
      if (regRdData != prev) changes++;
      prev = regRdData;
    end
    chk("R9", "counter steps in 12 cycles", changes, 4);

    // R7/R10: one-shot, P=3 D=1, interrupt enabled, idle low
    slotWrite(3'd3, 32'h0);
    slotWrite(3'd1, 32'd3);
    slotWrite(3'd5, 32'd1);
    slotWrite(3'd3, 32'h09);
    repeat (5) slotIdle(3'd3);
    @(negedge clk);
    chk("R7", "enable cleared", regRdData, 32'h08);
    chk("R7", "output idle", pwmOut, 0);
    readCheck(3'd4, 32'd1, "R7");
    chk("R10", "irq raised", irqOut, 1);
    slotWrite(3'd4, 32'd1);
    readCheck(3'd4, 32'd0, "R10");
    chk("R10", "irq dropped", irqOut, 0);

    // R10: clear write in the final tick cycle -> set wins
    slotWrite(3'd3, 32'h09);
    slotIdle(3'd0);
    slotIdle(3'd0);
    slotWrite(3'd4, 32'd1);
    readCheck(3'd4, 32'd1, "R10");

    // R11: control write in the final tick cycle wins over hardware clear
    slotWrite(3'd4, 32'd1);
    slotWrite(3'd3, 32'h09);
    slotIdle(3'd0);
    slotIdle(3'd0);
    slotWrite(3'd3, 32'h0B);
    readCheck(3'd3, 32'h0B, "R11");
    readCheck(3'd4, 32'd1, "R7");

    repeat (4) slotIdle(3'd0);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule